// File: doc/BRIEF.md
# Background comparator calibration sequencer

This block steps a redundant comparator bank through calibration one comparator at a time while the converter keeps running. Each thermometer level picks one comparator through its own select register. The candidates for a level form a sliding window: candidate `j` of level `m` is comparator `m + j`, so neighbouring levels share comparators. The sequencer owns the conversion-enable bits and the level select registers. It also holds, for every level, the candidate index of the best and the second-best comparator found so far.

Before a comparator is calibrated, every level that currently uses it is moved to that level's second-best candidate, so no level is ever left without a comparator. The sequencer then raises one calibration enable, which drives the stimulus generator, the calibration decoder, the return multiplexer and the timer. It waits for a done pulse from the measurement unit, which reports the new rank of the comparator. It then updates the best and second-best records and points every level back at its best candidate. Finally it rewrites the conversion enables so that exactly the selected comparators stay powered. A substitute that still serves another level therefore stays on.

Levels form the outer loop and candidates the inner loop. The loop wraps around and repeats for as long as the run input stays high.

Top module: `bgcal_sequencer`

## Requirements
- R1: After reset, `lvl_sel` is all zero, so each level `m` selects its candidate 0 (comparator `m`). Exactly comparators 0 to LEVELS-1 are conversion-enabled, and `cal_on` is low.
- R2: `cuc_id` equals level plus candidate. The candidate index advances after each completed calibration, and the level advances when the candidate wraps from CANDS-1 to 0. After level LEVELS-1 the walk returns to level 0, candidate 0.
- R3: If the comparator under calibration is not conversion-enabled, `cal_on` rises two cycles after the sequencer leaves idle or finishes the previous comparator, with no change to `conv_en` or `lvl_sel` in between.
- R4: If the comparator under calibration is enabled, the levels are examined one per cycle, level 0 first. For each level that selects it, that level's second-best candidate is enabled and selected in the same cycle. One cycle after the last level, the comparator's conversion enable is cleared, and `cal_on` rises on the following cycle.
- R5: `cal_on` stays high until a cycle in which `meas_done` is high, and falls on the next cycle. `meas_done` has no effect while `cal_on` is low.
- R6: Rank code `meas_rank` = 2'b10 means the comparator is the new best, 2'b01 means the new runner-up, and 2'b00 or 2'b11 means neither. On new best, a comparator that is not already best becomes best and the old best becomes second. On runner-up, a comparator that was best swaps places with the second, and one that was not best or second becomes second. Otherwise the records are unchanged.
- R7: One cycle after `cal_on` falls, every level selects its best candidate. One cycle later, `conv_en` is exactly the set of comparators selected by some level.
- R8: A comparator selected by any level is always conversion-enabled. While `cal_on` is high, the comparator under calibration is neither enabled nor selected.
- R9: With `run` low, the sequencer finishes the comparator in progress and then idles with `cal_on` low and the fabric unchanged. When `run` is raised again, it resumes with the next comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep calibrating while high |
| meas_done | input | 1 | One-cycle pulse from the measurement and ranking unit |
| meas_rank | input | 2 | Rank of the measured comparator, valid with `meas_done` |
| cal_on | output | 1 | Common enable for stimulus, decoder, return mux and timer |
| cuc_id | output | CMP_W | Index of the comparator under calibration |
| conv_en | output | COMPS | Per-comparator conversion enable |
| lvl_sel | output | LEVELS*SEL_W | Candidate select of each level, level m at bits m*SEL_W |

## Verification
The embedded assertions check on every cycle that selected comparators are always enabled, that the comparator under calibration is isolated, that the best and second-best records stay distinct, that the walk stays in range, and that the `cal_on` handshake holds and falls at the right time. The order in which levels are swapped, the choice of substitute, how each rank code moves the records, and the resume point after `run` drops can only be seen in the bench's scenarios. There, a behavioural model is compared with the outputs on every clock while rank codes and measurement delays vary.

// File: rtl/bgcal_pkg.sv
// Shared encodings for the calibration sequencer.
package bgcal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SCAN,
        ST_DROP,
        ST_CAL,
        ST_RESTORE,
        ST_SETTLE
    } seq_state_e;

    localparam logic [1:0] RANK_RUNNER = 2'b01;
    localparam logic [1:0] RANK_TOP    = 2'b10;

    localparam logic [2:0] RT_HOLD    = 3'd0;
    localparam logic [2:0] RT_SWAP    = 3'd1;
    localparam logic [2:0] RT_DROP    = 3'd2;
    localparam logic [2:0] RT_RESTORE = 3'd3;
    localparam logic [2:0] RT_SETTLE  = 3'd4;
endpackage

// File: rtl/bgcal_walk.sv
// Level/candidate walker: nested loop counter, candidate inner, level outer.
// Assumes CANDS >= 2 and LEVELS >= 2; advances once per step pulse.
module bgcal_walk #(
    parameter int LEVELS = 7,
    parameter int CANDS  = 4,
    parameter int LVL_W  = 3,
    parameter int SEL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [LVL_W-1:0] lvl,
    output logic [SEL_W-1:0] cand
);
    logic [LVL_W-1:0] lvl_q;
    logic [SEL_W-1:0] cand_q;

    // Advance the nested loop, wrapping the level after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            cand_q <= '0;
        end else if (step) begin
            if (cand_q == SEL_W'(CANDS - 1)) begin
                cand_q <= '0;
                lvl_q  <= (lvl_q == LVL_W'(LEVELS - 1)) ? '0 : lvl_q + 1'b1;
            end else begin
                cand_q <= cand_q + 1'b1;
            end
        end
    end

    assign lvl  = lvl_q;
    assign cand = cand_q;

    assert_walk_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lvl_q) < LEVELS) && (int'(cand_q) < CANDS));
endmodule

// File: rtl/bgcal_rank_store.sv
// Best / second-best candidate records per level, updated from the rank code.
// Assumes upd is a single-cycle pulse with lvl/cand/rank valid alongside.
module bgcal_rank_store #(
    parameter int LEVELS = 7,
    parameter int LVL_W  = 3,
    parameter int SEL_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic [LVL_W-1:0]        lvl,
    input  logic [SEL_W-1:0]        cand,
    input  logic [1:0]              rank,
    output logic [LEVELS*SEL_W-1:0] best_flat,
    output logic [LEVELS*SEL_W-1:0] second_flat
);
    import bgcal_pkg::*;

    logic [SEL_W-1:0] best_q [LEVELS];
    logic [SEL_W-1:0] sec_q  [LEVELS];

    // Apply the ranking outcome to the record of the addressed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < LEVELS; m++) begin
                best_q[m] <= '0;
                sec_q[m]  <= SEL_W'(1);
            end
        end else if (upd) begin
            for (int m = 0; m < LEVELS; m++) begin
                if (lvl == LVL_W'(m)) begin
                    if (rank == RANK_TOP) begin
                        if (cand != best_q[m]) begin
                            sec_q[m]  <= best_q[m];
                            best_q[m] <= cand;
                        end
                    end else if (rank == RANK_RUNNER) begin
                        if (cand == best_q[m]) begin
                            best_q[m] <= sec_q[m];
                            sec_q[m]  <= cand;
                        end else if (cand != sec_q[m]) begin
                            sec_q[m] <= cand;
                        end
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_flat
        assign best_flat[g*SEL_W +: SEL_W]   = best_q[g];
        assign second_flat[g*SEL_W +: SEL_W] = sec_q[g];

        assert_rank_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
            best_q[g] != sec_q[g]);
    end
endmodule

// File: rtl/bgcal_route.sv
// Routing fabric registers: level select registers and conversion enables.
// Executes one command per cycle; every register update completes in one cycle.
// Assumes best/second records never name the same candidate for a level.
module bgcal_route #(
    parameter int LEVELS = 7,
    parameter int COMPS  = 10,
    parameter int LVL_W  = 3,
    parameter int SEL_W  = 2,
    parameter int CMP_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              op,
    input  logic [LVL_W-1:0]        scan_lvl,
    input  logic [CMP_W-1:0]        cuc,
    input  logic                    cal_active,
    input  logic [LEVELS*SEL_W-1:0] best_flat,
    input  logic [LEVELS*SEL_W-1:0] second_flat,
    output logic [LEVELS*SEL_W-1:0] sel_flat,
    output logic [COMPS-1:0]        conv_en,
    output logic [COMPS-1:0]        used,
    output logic                    cuc_hit
);
    import bgcal_pkg::*;

    logic [SEL_W-1:0] sel_q [LEVELS];
    logic [COMPS-1:0] en_q;
    logic [COMPS-1:0] best_set;
    logic [SEL_W-1:0] scan_sel;
    logic [SEL_W-1:0] scan_sec;

    // Set of comparators currently selected, and set named by the best records.
    always_comb begin
        used     = '0;
        best_set = '0;
        for (int m = 0; m < LEVELS; m++) begin
            used[CMP_W'(m) + CMP_W'(sel_q[m])] = 1'b1;
            best_set[CMP_W'(m) + CMP_W'(best_flat[m*SEL_W +: SEL_W])] = 1'b1;
        end
    end

    // Current select and stored substitute of the level being scanned.
    always_comb begin
        scan_sel = '0;
        scan_sec = '0;
        for (int m = 0; m < LEVELS; m++) begin
            if (scan_lvl == LVL_W'(m)) begin
                scan_sel = sel_q[m];
                scan_sec = second_flat[m*SEL_W +: SEL_W];
            end
        end
    end

    assign cuc_hit = (CMP_W'(scan_lvl) + CMP_W'(scan_sel)) == cuc;

    // Fabric register writes commanded by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < LEVELS; m++) sel_q[m] <= '0;
            for (int i = 0; i < COMPS; i++) en_q[i] <= (i < LEVELS);
        end else begin
            case (op)
                RT_SWAP: begin
                    if (cuc_hit) begin
                        sel_q[scan_lvl] <= scan_sec;
                        en_q[CMP_W'(scan_lvl) + CMP_W'(scan_sec)] <= 1'b1;
                    end
                end
                RT_DROP: en_q[cuc] <= 1'b0;
                RT_RESTORE: begin
                    for (int m = 0; m < LEVELS; m++) sel_q[m] <= best_flat[m*SEL_W +: SEL_W];
                    en_q <= en_q | best_set;
                end
                RT_SETTLE: en_q <= used;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_sel
        assign sel_flat[g*SEL_W +: SEL_W] = sel_q[g];
    end
    assign conv_en = en_q;

    assert_sel_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (used & ~en_q) == '0);
    assert_cal_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> (!en_q[cuc] && !used[cuc]));
    assert_drop_unselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RT_DROP) |-> !used[cuc]);
endmodule

// File: rtl/bgcal_sequencer.sv
// Background calibration sequencer: walks levels and candidates, hot-swaps
// the comparator under calibration for stored substitutes, runs the
// measurement handshake and restores the fabric from the ranking outcome.
// Assumes meas_done is a single-cycle pulse given while cal_on is high.
module bgcal_sequencer #(
    parameter int  LEVELS = 7,
    parameter int  CANDS  = 4,
    localparam int COMPS  = LEVELS + CANDS - 1,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int SEL_W  = $clog2(CANDS),
    localparam int CMP_W  = $clog2(COMPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    meas_done,
    input  logic [1:0]              meas_rank,
    output logic                    cal_on,
    output logic [CMP_W-1:0]        cuc_id,
    output logic [COMPS-1:0]        conv_en,
    output logic [LEVELS*SEL_W-1:0] lvl_sel
);
    import bgcal_pkg::*;

    seq_state_e state_q, state_d;
    logic [LVL_W-1:0] scan_q;
    logic [LVL_W-1:0] lvl;
    logic [SEL_W-1:0] cand;
    logic [LEVELS*SEL_W-1:0] best_flat, second_flat;
    logic [COMPS-1:0] used;
    logic cuc_hit;
    logic [2:0] op;

    assign cuc_id = CMP_W'(lvl) + CMP_W'(cand);
    assign cal_on = (state_q == ST_CAL);

    // Next-state decision of the per-comparator sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (run) state_d = ST_CHECK;
            ST_CHECK:   state_d = conv_en[cuc_id] ? ST_SCAN : ST_CAL;
            ST_SCAN:    if (scan_q == LVL_W'(LEVELS - 1)) state_d = ST_DROP;
            ST_DROP:    state_d = ST_CAL;
            ST_CAL:     if (meas_done) state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_SETTLE;
            ST_SETTLE:  state_d = run ? ST_CHECK : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Fabric command issued in each phase.
    always_comb begin
        case (state_q)
            ST_SCAN:    op = RT_SWAP;
            ST_DROP:    op = RT_DROP;
            ST_RESTORE: op = RT_RESTORE;
            ST_SETTLE:  op = RT_SETTLE;
            default:    op = RT_HOLD;
        endcase
    end

    // State register and level scan pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CHECK)     scan_q <= '0;
            else if (state_q == ST_SCAN) scan_q <= scan_q + 1'b1;
        end
    end

    bgcal_walk #(.LEVELS(LEVELS), .CANDS(CANDS), .LVL_W(LVL_W), .SEL_W(SEL_W)) walk_i (
        .clk  (clk),
        .rst_n(rst_n),
        .step (state_q == ST_SETTLE),
        .lvl  (lvl),
        .cand (cand)
    );

    bgcal_rank_store #(.LEVELS(LEVELS), .LVL_W(LVL_W), .SEL_W(SEL_W)) rank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (cal_on && meas_done),
        .lvl        (lvl),
        .cand       (cand),
        .rank       (meas_rank),
        .best_flat  (best_flat),
        .second_flat(second_flat)
    );

    bgcal_route #(.LEVELS(LEVELS), .COMPS(COMPS), .LVL_W(LVL_W), .SEL_W(SEL_W),
                  .CMP_W(CMP_W)) route_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .scan_lvl   (scan_q),
        .cuc        (cuc_id),
        .cal_active (cal_on),
        .best_flat  (best_flat),
        .second_flat(second_flat),
        .sel_flat   (lvl_sel),
        .conv_en    (conv_en),
        .used       (used),
        .cuc_hit    (cuc_hit)
    );

    assert_cal_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_on && !meas_done) |=> cal_on);
    assert_cal_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_on && meas_done) |=> !cal_on);
    assert_skip_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !conv_en[cuc_id]) |=> cal_on);
    assert_idle_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (conv_en == used));
    assert_idle_best_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (lvl_sel == best_flat));
endmodule

// File: tb/bgcal_sequencer_tb_top.sv
// Bench: behavioural reference model compared with the outputs every clock.
module bgcal_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 7;
    localparam int K  = 4;
    localparam int C  = L + K - 1;
    localparam int SW = 2;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic meas_done = 1'b0;
    logic [1:0] meas_rank = 2'b00;
    logic cal_on;
    logic [CW-1:0] cuc_id;
    logic [C-1:0] conv_en;
    logic [L*SW-1:0] lvl_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    bgcal_sequencer #(.LEVELS(L), .CANDS(K)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .meas_done(meas_done),
        .meas_rank(meas_rank), .cal_on(cal_on), .cuc_id(cuc_id),
        .conv_en(conv_en), .lvl_sel(lvl_sel)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit started = 0;

    // model state: 0 idle,1 check,2 scan,3 drop,4 cal,5 restore,6 settle
    int m_st, m_lv, m_cd, m_sc;
    int m_sel[L];
    int m_best[L];
    int m_sec[L];
    bit m_en[C];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_lv = 0; m_cd = 0; m_sc = 0;
        for (int m = 0; m < L; m++) begin m_sel[m] = 0; m_best[m] = 0; m_sec[m] = 1; end
        for (int i = 0; i < C; i++) m_en[i] = (i < L);
    endtask

    task automatic model_rank(input logic [1:0] r);
        int b;
        b = m_best[m_lv];
        if (r == 2'b10) begin
            if (m_cd != b) begin m_sec[m_lv] = b; m_best[m_lv] = m_cd; end
        end else if (r == 2'b01) begin
            if (m_cd == b) begin m_best[m_lv] = m_sec[m_lv]; m_sec[m_lv] = m_cd; end
            else if (m_cd != m_sec[m_lv]) m_sec[m_lv] = m_cd;
        end
    endtask

    // Reference model step at each rising edge, plus watchdog.
    always @(posedge clk) begin
        int id;
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
        id = m_lv + m_cd;
        if (!rst_n) model_reset();
        else begin
            case (m_st)
                0: if (run) m_st = 1;
                1: begin m_sc = 0; m_st = m_en[id] ? 2 : 4; end
                2: begin
                    if (m_sc + m_sel[m_sc] == id) begin
                        m_sel[m_sc] = m_sec[m_sc];
                        m_en[m_sc + m_sec[m_sc]] = 1'b1;
                    end
                    if (m_sc == L - 1) m_st = 3; else m_sc++;
                end
                3: begin m_en[id] = 1'b0; m_st = 4; end
                4: if (meas_done) begin model_rank(meas_rank); m_st = 5; end
                5: begin
                    for (int m = 0; m < L; m++) begin
                        m_sel[m] = m_best[m];
                        m_en[m + m_best[m]] = 1'b1;
                    end
                    m_st = 6;
                end
                default: begin
                    for (int i = 0; i < C; i++) m_en[i] = 1'b0;
                    for (int m = 0; m < L; m++) m_en[m + m_sel[m]] = 1'b1;
                    if (m_cd == K - 1) begin m_cd = 0; m_lv = (m_lv == L - 1) ? 0 : m_lv + 1; end
                    else m_cd++;
                    m_st = run ? 1 : 0;
                end
            endcase
        end
        started = 1;
    end

    function automatic logic [1:0] rank_pat(input int n);
        case (n % 5)
            0: return 2'b10;
            1: return 2'b00;
            2: return 2'b01;
            3: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    bit stray_req = 0;
    int cal_cnt = 0;
    int n_cal = 0;
    int dly = 1;

    // Compare outputs with the model, then drive the measurement responder.
    always @(negedge clk) begin
        logic [C-1:0] e_en;
        logic [L*SW-1:0] e_sel;
        if (started) begin
            for (int i = 0; i < C; i++) e_en[i] = m_en[i];
            for (int m = 0; m < L; m++) e_sel[m*SW +: SW] = SW'(m_sel[m]);
            chk("R4 R7 conv_en", 64'(conv_en), 64'(e_en));
            chk("R4 R7 lvl_sel", 64'(lvl_sel), 64'(e_sel));
            chk("R3 R5 cal_on", 64'(cal_on), 64'(m_st == 4));
            chk("R2 cuc_id", 64'(cuc_id), 64'(m_lv + m_cd));
            if (cal_on === 1'b1) begin
                bit hit;
                hit = 0;
                for (int m = 0; m < L; m++)
                    if (m + int'(lvl_sel[m*SW +: SW]) == int'(cuc_id)) hit = 1;
                chk("R8 isolated", {62'd0, conv_en[cuc_id], hit}, 64'd0);
            end
        end
        if (stray_req && cal_on !== 1'b1) begin
            meas_done = 1'b1; meas_rank = 2'b10; stray_req = 0;
        end else if (cal_on === 1'b1) begin
            cal_cnt++;
            if (cal_cnt == dly) begin
                meas_done = 1'b1; meas_rank = rank_pat(n_cal);
                n_cal++; dly = (n_cal % 4) + 1;
            end else meas_done = 1'b0;
        end else begin
            cal_cnt = 0; meas_done = 1'b0;
        end
    end

    initial begin
        logic [C-1:0] held_en;
        logic [L*SW-1:0] held_sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 conv_en reset", 64'(conv_en), 64'((1 << L) - 1));
        chk("R1 lvl_sel reset", 64'(lvl_sel), 64'd0);
        chk("R1 cal_on reset", 64'(cal_on), 64'd0);
        // R5 done pulse while idle is ignored
        held_en = conv_en; held_sel = lvl_sel;
        stray_req = 1;
        repeat (3) @(negedge clk);
        chk("R5 stray done cal_on", 64'(cal_on), 64'd0);
        chk("R5 stray done conv_en", 64'(conv_en), 64'(held_en));
        chk("R5 stray done lvl_sel", 64'(lvl_sel), 64'(held_sel));
        // Long run: several full passes, wraps the outer loop (R2)
        run = 1'b1;
        repeat (1000) @(negedge clk);
        run = 1'b0;
        for (int k = 0; k < 200 && m_st != 0; k++) @(negedge clk);
        held_en = conv_en; held_sel = lvl_sel;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R9 idle cal_on", 64'(cal_on), 64'd0);
            chk("R9 idle conv_en", 64'(conv_en), 64'(held_en));
            chk("R9 idle lvl_sel", 64'(lvl_sel), 64'(held_sel));
        end
        for (int m = 0; m < L; m++)
            chk("R6 level selects best", 64'(lvl_sel[m*SW +: SW]), 64'(m_best[m]));
        // Resume from the next comparator
        run = 1'b1;
        repeat (400) @(negedge clk);
        run = 1'b0;
        repeat (80) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule